// File: doc/BRIEF.md
# Memory-Mapped General-Purpose I/O Port

This block is one parallel I/O port of eight pins, configured and accessed through a plain synchronous register bus made of an address, a write strobe, write data and combinational read data. Software chooses, pin by pin, whether each pin drives or listens, what level it drives, whether the pad keeps its pull device switched on and whether the pad runs at reduced drive strength. The block emits only the digital control lines for the pad; the resistors and drivers themselves sit outside it.

Reading the data location returns one byte in which every listening pin shows its synchronized pad level and every driving pin shows the value last stored for it. A write to the data location updates only the bits whose pins currently drive. A single port-wide alternate-function select hands the pad output value and output enable to another peripheral; while it is set, the stored registers are kept but do not reach the pads.

There are two ownership modes: port mode (select low, the registers drive the pads) and peripheral mode (select high, the peripheral drives them). Moving between them is combinational: raising the select enters peripheral mode, lowering it returns to port mode.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0x00, the pull-enable register reads 0xFF, the reduced-drive register reads 0x00, the output latch is 0x00, and the port owns the pins.
- R2: Offset 1 holds the direction register; a bit value of 1 makes that pin drive and 0 makes it listen. It reads back as written, and in port mode pad_oe equals it one cycle after the write.
- R3: A write to offset 0 changes the output latch only in bits whose direction bit is 1. Bits whose direction bit is 0 keep their earlier latch value. In port mode pad_out shows the latch.
- R4: A read of offset 0 returns, for each bit, the latch value when the direction bit is 1 and the synchronized pin level when it is 0.
- R5: Offset 2 holds the pull-enable register and offset 3 holds the reduced-drive register; both read back as written, and pad_low_drive equals the reduced-drive register.
- R6: pad_pull_en is the pull-enable register with every bit cleared whose pin is currently driving (direction bit in port mode, alt_oe bit in peripheral mode).
- R7: While alt_sel is 1, pad_out equals alt_out and pad_oe equals alt_oe; when alt_sel returns to 0 the pads show the unchanged register contents again.
- R8: A change on pin_in appears in an offset-0 read two clock edges later, and not after only one edge.
- R9: Reads of offsets 4 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | Pad levels, asynchronous |
| alt_sel | input | 1 | 1 hands the pads to the alternate peripheral |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| pad_out | output | 8 | Value driven to each pad |
| pad_oe | output | 8 | Output enable per pad |
| pad_pull_en | output | 8 | Pull device enable per pad |
| pad_low_drive | output | 8 | Reduced drive select per pad |

## Verification
A wrong bit in the latch or the direction register shows at pad_out or pad_oe as soon as the pins are in port mode, and in the very next offset-0 read. A bad merge or a missing synchronizer stage shows up as a read value that is off by one cycle or belongs to the wrong source, so the bench reads both one and two edges after a pin change. A stuck ownership select shows at once as pads that ignore alt_out and alt_oe, or that keep them after release.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_DIR   = 3'd1,
        OFS_PULL  = 3'd2,
        OFS_RDRV  = 3'd3
    } reg_ofs_e;

    typedef enum logic {
        OWN_PORT = 1'b0,
        OWN_ALT  = 1'b1
    } owner_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            assert_two_edge_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd2) |-> (sync_out == $past(async_in, 2)))
                else $error("synchronizer latency wrong");
        end
    endgenerate
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] pull_q,
    output logic [WIDTH-1:0] rdrv_q
);
    logic wr_data, wr_dir, wr_pull, wr_rdrv;

    always_comb begin
        wr_data = 1'b0;
        wr_dir  = 1'b0;
        wr_pull = 1'b0;
        wr_rdrv = 1'b0;
        if (bus_we) begin
            unique case (bus_addr)
                OFS_DATA: wr_data = 1'b1;
                OFS_DIR:  wr_dir  = 1'b1;
                OFS_PULL: wr_pull = 1'b1;
                OFS_RDRV: wr_rdrv = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '1;
            rdrv_q  <= '0;
        end else begin
            if (wr_data) latch_q <= (bus_wdata & dir_q) | (latch_q & ~dir_q);
            if (wr_dir)  dir_q   <= bus_wdata;
            if (wr_pull) pull_q  <= bus_wdata;
            if (wr_rdrv) rdrv_q  <= bus_wdata;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DATA: bus_rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
            OFS_DIR:  bus_rdata = dir_q;
            OFS_PULL: bus_rdata = pull_q;
            OFS_RDRV: bus_rdata = rdrv_q;
            default:  bus_rdata = '0;
        endcase
    end

    assert_input_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DATA) |=>
            ((latch_q & ~$past(dir_q)) == ($past(latch_q) & ~$past(dir_q))))
        else $error("write touched a listening bit");

    assert_dir_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)))
        else $error("direction write lost");
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  owner_e           owner,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic [WIDTH-1:0] rdrv_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pull_en,
    output logic [WIDTH-1:0] pad_low_drive
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_pin
        logic drv_b;
        always_comb begin
            unique case (owner)
                OWN_PORT: begin
                    pad_out[b] = latch_q[b];
                    drv_b      = dir_q[b];
                end
                OWN_ALT: begin
                    pad_out[b] = alt_out[b];
                    drv_b      = alt_oe[b];
                end
            endcase
        end
        assign pad_oe[b]        = drv_b;
        assign pad_pull_en[b]   = pull_q[b] & ~drv_b;
        assign pad_low_drive[b] = rdrv_q[b];
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W,
    parameter int AW    = ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             alt_sel,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pull_en,
    output logic [WIDTH-1:0] pad_low_drive
);
    logic [WIDTH-1:0] pin_sync, latch_q, dir_q, pull_q, rdrv_q;
    owner_e owner;

    always_comb begin
        unique case (alt_sel)
            1'b1:    owner = OWN_ALT;
            default: owner = OWN_PORT;
        endcase
    end

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
        .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .rdrv_q(rdrv_q)
    );

    gpio_padmux #(.WIDTH(WIDTH)) padmux_i (
        .owner(owner), .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q),
        .rdrv_q(rdrv_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_low_drive(pad_low_drive)
    );

    assert_no_pull_on_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0)
        else $error("pull left on a driving pin");

    assert_alt_takes_pads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alt_sel |-> (pad_out == alt_out && pad_oe == alt_oe))
        else $error("peripheral does not own pads");
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h47;
    logic       alt_sel = 1'b0;
    logic [7:0] alt_out = '0;
    logic [7:0] alt_oe = '0;
    logic [7:0] pad_out, pad_oe, pad_pull_en, pad_low_drive;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_low_drive(pad_low_drive)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected read per falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata, it.exp);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic settle;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R1 reset state
        rd(3'd1, 8'h00, "R1 dir");
        rd(3'd2, 8'hFF, "R1 pull");
        rd(3'd3, 8'h00, "R1 rdrv");
        rd(3'd0, 8'h47, "R1/R4 all inputs");
        settle;
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        rd(3'd5, 8'h00, "R9 offset5");
        rd(3'd7, 8'h00, "R9 offset7");
        // R2 direction upper nibble out
        wr(3'd1, 8'hF0);
        settle;
        check("R2 pad_oe", pad_oe, 8'hF0);
        rd(3'd1, 8'hF0, "R2 readback");
        // R3 data only to drivers
        wr(3'd0, 8'hAB);
        settle;
        check("R3 pad_out", pad_out, 8'hA0);
        rd(3'd0, 8'hA7, "R4 merged");
        check("R6 pull mask", pad_pull_en, 8'h0F);
        // R5
        wr(3'd2, 8'h3C);
        rd(3'd2, 8'h3C, "R5 pull readback");
        settle;
        check("R6 pull mask2", pad_pull_en, 8'h0C);
        wr(3'd3, 8'h55);
        rd(3'd3, 8'h55, "R5 rdrv readback");
        settle;
        check("R5 low drive", pad_low_drive, 8'h55);
        // R3 all outputs then all inputs
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'h12);
        rd(3'd0, 8'h12, "R3 full out");
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h99);
        wr(3'd1, 8'hFF);
        rd(3'd0, 8'h12, "R3 ignored when input");
        settle;
        check("R3 pad_out kept", pad_out, 8'h12);
        // R7 alternate function
        wr(3'd1, 8'h0F);
        @(posedge clk); #1;
        alt_sel = 1'b1; alt_out = 8'h5A; alt_oe = 8'hC3;
        settle;
        check("R7 alt out", pad_out, 8'h5A);
        check("R7 alt oe", pad_oe, 8'hC3);
        check("R6 alt pull", pad_pull_en, 8'h3C);
        @(posedge clk); #1;
        alt_sel = 1'b0;
        settle;
        check("R7 release oe", pad_oe, 8'h0F);
        check("R7 release out", pad_out, 8'h12);
        rd(3'd1, 8'h0F, "R7 dir kept");
        // R8 synchronizer latency
        wr(3'd1, 8'h00);
        @(posedge clk); #1;
        pin_in = 8'h81;
        rd(3'd0, 8'h47, "R8 one edge old");
        rd(3'd0, 8'h81, "R8 two edges new");
        repeat (3) @(posedge clk);
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (200000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule